// File: doc/BRIEF.md
# Direction-Controlled Up/Down Compare Timer

This block is a 16-bit binary counter that software drives through a small write port and reads back through a separate read port. The counter steps once per tick. A tick is either an external tick-enable input or an internal divide-by-4 of the system clock. The step direction is set by a direction-mode field in the mode register. In one of its modes, the direction follows an external level input from one step to the next.

The counter runs between zero and a loop limit held in register A. Counting up past the limit returns it to zero. Counting down from zero reloads it with the limit. Register B holds a compare value. Each counted step that lands on B produces a one-cycle compare pulse and sets a sticky interrupt flag. The flag drives the interrupt line when its enable bit is also set.

Starting the timer takes two writes. The first arms it: the arm bit is set and the enable bit is left clear. The second sets the enable. While the arm bit is clear, the counter and an internal arm flip-flop are forced to zero. If the arm write is skipped, the tick in the first cycle after the start is dropped.

Top module: `updn_cmp_timer`

## Requirements
- R1: After reset, every register reads 0, the counter reads 0, and both `cmp_pulse` and `irq` are low.
- R2: While mode bit 14 (arm) is 0, the counter is cleared to 0 on the next clock edge and ticks are ignored.
- R3: With arm = 1 and mode bit 15 (enable) = 0, ticks are ignored and the counter holds its value.
- R4: The write that sets enable does not count, even with a tick present. A tick in the following cycle counts. If the arm bit was 0 before the start write, the tick in the first cycle after it is dropped.
- R5: Mode bits 11:10 set the direction: 2'b00 up, 2'b01 down, 2'b10 up while `dir_in` is 1 and down while it is 0, 2'b11 up. A change of `dir_in` takes effect on the next step.
- R6: Counting up from a value greater than or equal to register A yields 0.
- R7: Counting down from 0 yields the value of register A.
- R8: When a counted step makes the counter equal to register B, in either direction, `cmp_pulse` is high for the one cycle after that edge, and interrupt flag bit 0 of address 3 is set in the same edge.
- R9: Writing address 3 stores the interrupt enable from bit 1 and clears the flag when bit 0 is 0. Writing 1 to bit 0 does not set the flag. `irq` is high exactly when flag and enable are both 1.
- R10: Clock select (mode bits 2:0) of 3'b011 steps the counter every 4th clock and ignores `ext_tick`. The prescaler is held at 0 while arm is 0, so the first step falls on the 4th edge after the arm write. Any other select uses `ext_tick`.
- R11: Register map: address 0 mode, 1 limit A, 2 compare B, 3 interrupt control, 4 counter (read-only). Reads return the stored values combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| ext_tick | input | 1 | External tick enable |
| dir_in | input | 1 | External direction level (1 = up) |
| cmp_pulse | output | 1 | One-cycle compare-B match pulse |
| irq | output | 1 | Interrupt request (flag and enable) |

## Verification
A wrong counter value appears at read address 4 in the cycle after the faulty step. Every later step then differs as well, because each step builds on the one before. A wrong arm flip-flop shows as a gained or lost first tick after a start write. A stale prescaler moves the first internal step away from the 4th edge. Wrong flag or pulse logic appears on `cmp_pulse` and `irq` in the cycle right after the step that reaches B, and on `irq` again after each write to address 3.

// File: rtl/updn_cmp_timer.sv
`timescale 1ns/100ps
module updn_cmp_timer #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          ext_tick,
  input  logic          dir_in,
  output logic          cmp_pulse,
  output logic          irq
);
  localparam int EN_BIT  = W - 1;
  localparam int ARM_BIT = W - 2;
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_LIM  = AW'(1);
  localparam logic [AW-1:0] A_CMP  = AW'(2);
  localparam logic [AW-1:0] A_IRQ  = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(4);

  logic [W-1:0] mode_q, lim_q, cmp_q, cnt_q;
  logic         flag_q, ie_q, sr_q, pulse_q;
  logic [1:0]   pre_q;

  wire       run_en   = mode_q[EN_BIT];
  wire       armed    = mode_q[ARM_BIT];
  wire [1:0] dmode    = mode_q[11:10];
  wire       int_div  = (mode_q[2:0] == 3'b011);
  wire       tick     = int_div ? (pre_q == 2'd3) : ext_tick;
  wire       step     = run_en & armed & sr_q & tick;
  wire       go_up    = (dmode == 2'b01) ? 1'b0 : (dmode == 2'b10) ? dir_in : 1'b1;

  logic [W-1:0] nxt;
  always_comb begin
    if (go_up) nxt = (cnt_q >= lim_q) ? '0 : cnt_q + 1'b1;
    else       nxt = (cnt_q == '0) ? lim_q : cnt_q - 1'b1;
  end

  wire hit = step && (nxt == cmp_q);
  wire wr_irq = wr_en && (wr_addr == A_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      lim_q  <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode_q <= wr_data;
        A_LIM:   lim_q  <= wr_data;
        A_CMP:   cmp_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= 1'b0;
      pre_q <= 2'd0;
    end else begin
      sr_q  <= armed;
      pre_q <= armed ? pre_q + 2'd1 : 2'd0;
      if (!armed)    cnt_q <= '0;
      else if (step) cnt_q <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (wr_irq) ie_q <= wr_data[1];
      if (hit)         flag_q <= 1'b1;
      else if (wr_irq) flag_q <= flag_q & wr_data[0];
    end
  end

  assign cmp_pulse = pulse_q;
  assign irq       = flag_q & ie_q;

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = mode_q;
      A_LIM:   rd_data = lim_q;
      A_CMP:   rd_data = cmp_q;
      A_IRQ:   rd_data = {{(W-2){1'b0}}, ie_q, flag_q};
      A_CNT:   rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end

  assert_clear_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> cnt_q == '0);
  assert_hold_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !run_en) |=> $stable(cnt_q));
  assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && go_up && cnt_q >= lim_q) |=> cnt_q == '0);
  assert_reload_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !go_up && cnt_q == '0) |=> cnt_q == $past(lim_q));
  assert_pulse_after_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> $past(step));
  assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> flag_q);
  assert_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> cmp_pulse);
endmodule

// File: tb/updn_cmp_timer_bench.sv
`timescale 1ns/100ps
module updn_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd4;
  logic [15:0] rd_data;
  logic        ext_tick = 1'b0;
  logic        dir_in = 1'b1;
  logic        cmp_pulse, irq;

  always #2.5 clk = ~clk;

  updn_cmp_timer u_updn_cmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_tick(ext_tick), .dir_in(dir_in),
    .cmp_pulse(cmp_pulse), .irq(irq));

  typedef struct {
    int unsigned cnt;
    bit          pulse;
    bit          irq;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_mode = '0, m_lim = '0, m_cmp = '0, m_cnt = '0;
  bit m_flag = 0, m_ie = 0, m_sr = 0;
  int unsigned m_pre = 0;

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit dr, input bit we, input int unsigned a,
                      input logic [15:0] d, input string tag);
    bit en, nld, up, tkk, run, pulse, nflag;
    logic [15:0] ncnt;
    @(negedge clk);
    ext_tick = tk; dir_in = dr; wr_en = we; wr_addr = 3'(a); wr_data = d;
    en  = m_mode[15];
    nld = m_mode[14];
    tkk = (m_mode[2:0] == 3'b011) ? (m_pre == 3) : tk;
    run = en && nld && m_sr && tkk;
    up  = (m_mode[11:10] == 2'b01) ? 1'b0 : (m_mode[11:10] == 2'b10) ? dr : 1'b1;
    ncnt = m_cnt; pulse = 0;
    if (!nld) ncnt = '0;
    else if (run) begin
      if (up) ncnt = (m_cnt >= m_lim) ? 16'h0 : m_cnt + 16'h1;
      else    ncnt = (m_cnt == 0) ? m_lim : m_cnt - 16'h1;
      pulse = (ncnt == m_cmp);
    end
    nflag = m_flag;
    if (we && a == 3) begin nflag = m_flag & d[0]; m_ie = d[1]; end
    if (pulse) nflag = 1;
    m_sr  = nld;
    m_pre = nld ? (m_pre + 1) % 4 : 0;
    m_cnt = ncnt; m_flag = nflag;
    if (we && a == 0) m_mode = d;
    if (we && a == 1) m_lim = d;
    if (we && a == 2) m_cmp = d;
    exp_q.push_back('{cnt: ncnt, pulse: pulse, irq: m_flag && m_ie, tag: tag});
    @(posedge clk);
    #1.5;
    wr_en = 1'b0; ext_tick = 1'b0;
  endtask

  task automatic rd(input int unsigned a, input int unsigned exp, input string tag);
    rd_addr = 3'(a);
    #0.2;
    chk(tag, rd_data, exp);
    rd_addr = 3'd4;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      chk({it.tag, " count"}, rd_data, it.cnt);
      chk({it.tag, " pulse"}, cmp_pulse, it.pulse);
      chk({it.tag, " irq"}, irq, it.irq);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1.5 rst_n = 1'b1;
    for (int a = 0; a < 5; a++) rd(a, 0, "R1 reset reg");
    chk("R1 irq", irq, 0);
    chk("R1 pulse", cmp_pulse, 0);

    step(0, 1, 1, 1, 16'd5, "R11 write A");
    step(0, 1, 1, 2, 16'd3, "R11 write B");
    step(0, 1, 1, 3, 16'h0002, "R11 write ie");
    rd(1, 5, "R11 readback A");
    rd(2, 3, "R11 readback B");
    rd(3, 2, "R11 readback irq ctl");

    step(1, 1, 1, 0, 16'h4000, "R3 arm write");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, "R3 armed tick ignored");
    rd(4, 0, "R3 count held");
    step(1, 1, 1, 0, 16'hC000, "R4 start write no count");
    rd(4, 0, "R4 no count on start edge");
    step(1, 1, 0, 0, 0, "R4 first count");
    rd(4, 1, "R4 count after start");
    step(1, 1, 0, 0, 0, "R5 up");
    step(1, 1, 0, 0, 0, "R8 up match");
    rd(3, 3, "R8 flag set");
    step(1, 1, 0, 0, 0, "R5 up");
    step(1, 1, 0, 0, 0, "R5 up");
    step(1, 1, 0, 0, 0, "R6 wrap to zero");
    rd(4, 0, "R6 wrapped");
    step(0, 1, 0, 0, 0, "R5 no tick hold");
    step(0, 1, 1, 3, 16'h0002, "R9 clear flag");
    chk("R9 irq low after clear", irq, 0);
    step(0, 1, 1, 3, 16'h0003, "R9 write 1 no set");
    rd(3, 2, "R9 flag stays clear");
    step(0, 1, 1, 3, 16'h0000, "R9 disable ie");

    step(0, 1, 1, 0, 16'hC400, "R5 down mode");
    step(1, 1, 0, 0, 0, "R7 reload down");
    rd(4, 5, "R7 reloaded to A");
    step(1, 1, 0, 0, 0, "R5 down");
    step(1, 1, 0, 0, 0, "R8 down match");
    rd(3, 1, "R8 flag set down ie off");
    chk("R9 irq masked", irq, 0);
    step(1, 1, 1, 3, 16'h0002, "R9 clear and enable");

    step(0, 1, 1, 0, 16'hC800, "R5 ext dir mode");
    step(1, 1, 0, 0, 0, "R5 ext up");
    step(1, 1, 0, 0, 0, "R5 ext up");
    step(1, 0, 0, 0, 0, "R5 ext down mid count");
    step(1, 0, 0, 0, 0, "R5 ext down");
    step(1, 1, 0, 0, 0, "R5 ext up again");
    step(0, 1, 1, 0, 16'hCC00, "R5 mode 11");
    step(1, 0, 0, 0, 0, "R5 mode 11 counts up");

    step(1, 1, 1, 0, 16'h0000, "R2 disarm write");
    step(1, 1, 0, 0, 0, "R2 cleared");
    rd(4, 0, "R2 count zero");
    step(1, 1, 0, 0, 0, "R2 tick ignored");
    step(1, 1, 1, 0, 16'hC000, "R4 start without arm");
    step(1, 1, 0, 0, 0, "R4 first tick lost");
    rd(4, 0, "R4 lost tick");
    step(1, 1, 0, 0, 0, "R4 counts after loss");
    rd(4, 1, "R4 count one");

    step(0, 1, 1, 0, 16'h0003, "R10 disarm div4");
    step(1, 1, 1, 0, 16'h4003, "R10 arm div4");
    step(1, 1, 1, 0, 16'hC003, "R10 start div4");
    for (int i = 0; i < 11; i++) step(1, 1, 0, 0, 0, "R10 div4 run");
    rd(4, 3, "R10 three steps in 12 edges");
    step(0, 1, 0, 0, 0, "R10 idle");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule